// File: doc/BRIEF.md
# Display controller command sequencer

This block sits behind a serial host link of a bistable display controller. Each received byte comes with a tag that marks it as a command or a parameter. The block decodes a small command set. Panel configuration and the power-down spacing are written into registers. Power-up and power-down each run as a timed sequence. A soft reset locks out the link for a fixed time, and deep sleep can be entered only with a guard code.

The block drives an active-low busy line. The host may send bytes only while that line is high. It also drives a booster enable and a source-driver enable, and it flags deep sleep. A frame tick paces the power-down sequence and a microsecond tick paces the soft-reset lockout. A voltage-ready input stands in for the regulators. A waveform-active input stands in for the refresh engine. Bytes of the data-start stream are passed out one at a time for a frame store.

Top module: `epd_cmd_seq`

## Requirements
- R1: While `rst_n` is low and after it is released: `busy_n`=1, `boost_en`=0, `src_en`=0, `deep_sleep`=0, `panel_cfg0`=0x0F, `panel_cfg1`=0x00, `pof_code`=0, `drop_err`=0, `pix_we`=0.
- R2: A byte is a command when `byte_is_data`=0 and a parameter when it is 1. After command 0x00 the first parameter is stored in `panel_cfg0` and the second parameter's bits [4:0] in `panel_cfg1`. Any further parameter bytes are ignored.
- R3: A parameter byte that no pending command expects, or that follows an undefined command, changes no register and produces no `pix_we`.
- R4: Command 0x04 sets `boost_en` and `src_en` at once. `busy_n` stays 0 until `volt_ready` is sampled high, and returns to 1 on that edge.
- R5: Command 0x02 clears `src_en` at once and holds `busy_n` at 0. `boost_en` falls, and `busy_n` returns to 1, on the N-th `frame_tick` after that, where N = `pof_code`+1. The register contents are kept.
- R6: Command 0x03 takes one parameter, and bits [5:4] of that parameter are stored in `pof_code`.
- R7: If bit 1 of the first 0x00 parameter is 0 (and bit 0 is 1), `boost_en` and `src_en` are cleared, and `panel_cfg0` holds the written value.
- R8: If bit 0 of the first 0x00 parameter is 0, every register returns to its R1 value and `boost_en`/`src_en` are cleared. `busy_n` stays 0 until RST_US (default 50) `us_tick` pulses have been counted, and bytes sent in that window change nothing.
- R9: Command 0x07 followed by parameter 0xA5 sets `deep_sleep`, clears `boost_en` and holds `busy_n` at 0. Any other parameter value has no effect.
- R10: Deep sleep is left only by `rst_n`. Bytes sent during deep sleep, 0x04 included, have no effect.
- R11: `busy_n` is 0 in every cycle where `wave_active` is 1.
- R12: A byte presented while `busy_n` is 0 is dropped, and `drop_err` is set in the next cycle. `drop_err` then stays 1 until `rst_n`.
- R13: After command 0x10, each parameter byte appears on `pix_byte` with `pix_we` high for exactly the cycle after it is accepted. The stream ends at the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| byte_valid | input | 1 | A byte is presented this cycle |
| byte_is_data | input | 1 | 1 = parameter byte, 0 = command byte |
| byte_val | input | 8 | Byte value |
| volt_ready | input | 1 | All supply voltages are ready |
| wave_active | input | 1 | A display waveform is being output |
| frame_tick | input | 1 | One-cycle pulse per frame |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| busy_n | output | 1 | Active-low busy |
| boost_en | output | 1 | Booster enable |
| src_en | output | 1 | Source-driver enable |
| deep_sleep | output | 1 | Deep-sleep state |
| panel_cfg0 | output | 8 | First panel-setting register |
| panel_cfg1 | output | 5 | Second panel-setting register |
| pof_code | output | 2 | Power-off interval code |
| drop_err | output | 1 | Sticky flag for a byte sent while busy |
| pix_we | output | 1 | Stream byte strobe |
| pix_byte | output | 8 | Stream byte |

## Verification
The assertions check on every cycle that:
- a byte sent while busy raises the sticky error on the next edge, and the error then stays set;
- deep sleep is held until hardware reset and keeps the booster off;
- the booster and source enables rise only after a 0x04 command;
- the configuration registers and stream strobes change only after an accepted byte.

Some behaviour only the bench scenarios can show:
- the exact frame count of the power-down interval for a chosen code;
- the length of the microsecond lockout;
- that registers keep or lose their values across the booster shutdown, soft reset and ignored bytes;
- the rejection of a wrong guard code.

// File: rtl/epd_seq_pkg.sv
package epd_seq_pkg;
  localparam logic [7:0] OP_PANEL  = 8'h00;
  localparam logic [7:0] OP_PWROFF = 8'h02;
  localparam logic [7:0] OP_POFSEQ = 8'h03;
  localparam logic [7:0] OP_PWRON  = 8'h04;
  localparam logic [7:0] OP_SLEEP  = 8'h07;
  localparam logic [7:0] OP_STREAM = 8'h10;
  localparam logic [7:0] SLEEP_KEY = 8'hA5;
  localparam logic [7:0] CFG0_DEF  = 8'h0F;
  localparam logic [4:0] CFG1_DEF  = 5'h00;

  typedef enum logic [2:0] {
    EXP_NONE, EXP_CFG0, EXP_CFG1, EXP_POF, EXP_KEY, EXP_STREAM
  } expect_t;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_PWRUP, SQ_PWROFF, SQ_LOCK, SQ_SLEEP
  } seq_t;

  // frames between source and booster shutdown for a stored code
  function automatic logic [2:0] pof_frames(input logic [1:0] code);
    return {1'b0, code} + 3'd1;
  endfunction
endpackage

// File: rtl/esq_decode.sv
module esq_decode
  import epd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic       is_data,
  input  logic [7:0] val,
  output logic       ev_pon,
  output logic       ev_poff,
  output logic       ev_srst,
  output logic       ev_shd,
  output logic       ev_sleep,
  output logic [7:0] cfg0,
  output logic [4:0] cfg1,
  output logic [1:0] pof_code,
  output logic       pix_we,
  output logic [7:0] pix_byte
);
  expect_t exp_q;

  logic acc_cmd, acc_dat;
  assign acc_cmd = acc && !is_data;
  assign acc_dat = acc && is_data;

  assign ev_pon   = acc_cmd && (val == OP_PWRON);
  assign ev_poff  = acc_cmd && (val == OP_PWROFF);
  assign ev_srst  = acc_dat && (exp_q == EXP_CFG0) && !val[0];
  assign ev_shd   = acc_dat && (exp_q == EXP_CFG0) && val[0] && !val[1];
  assign ev_sleep = acc_dat && (exp_q == EXP_KEY) && (val == SLEEP_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q    <= EXP_NONE;
      cfg0     <= CFG0_DEF;
      cfg1     <= CFG1_DEF;
      pof_code <= 2'd0;
      pix_we   <= 1'b0;
      pix_byte <= 8'h00;
    end else begin
      pix_we <= 1'b0;
      if (acc_cmd) begin
        case (val)
          OP_PANEL:  exp_q <= EXP_CFG0;
          OP_POFSEQ: exp_q <= EXP_POF;
          OP_SLEEP:  exp_q <= EXP_KEY;
          OP_STREAM: exp_q <= EXP_STREAM;
          default:   exp_q <= EXP_NONE;
        endcase
      end else if (acc_dat) begin
        case (exp_q)
          EXP_CFG0: begin
            if (!val[0]) begin
              cfg0     <= CFG0_DEF;
              cfg1     <= CFG1_DEF;
              pof_code <= 2'd0;
              exp_q    <= EXP_NONE;
            end else begin
              cfg0  <= val;
              exp_q <= EXP_CFG1;
            end
          end
          EXP_CFG1: begin
            cfg1  <= val[4:0];
            exp_q <= EXP_NONE;
          end
          EXP_POF: begin
            pof_code <= val[5:4];
            exp_q    <= EXP_NONE;
          end
          EXP_KEY: exp_q <= EXP_NONE;
          EXP_STREAM: begin
            pix_we   <= 1'b1;
            pix_byte <= val;
          end
          default: exp_q <= EXP_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/esq_power.sv
module esq_power
  import epd_seq_pkg::*;
#(
  parameter int RST_US = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_pon,
  input  logic       ev_poff,
  input  logic       ev_srst,
  input  logic       ev_shd,
  input  logic       ev_sleep,
  input  logic [1:0] pof_code,
  input  logic       volt_ready,
  input  logic       frame_tick,
  input  logic       us_tick,
  output logic       seq_busy,
  output logic       boost_en,
  output logic       src_en,
  output logic       deep_sleep
);
  localparam int LW = $clog2(RST_US + 1);
  localparam int CW = (LW > 3) ? LW : 3;
  localparam logic [CW-1:0] LOCK_LAST = CW'(RST_US - 1);

  seq_t          st_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] pof_last;

  assign pof_last = CW'(pof_frames(pof_code)) - CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      cnt_q    <= '0;
      boost_en <= 1'b0;
      src_en   <= 1'b0;
    end else if (ev_srst) begin
      st_q     <= SQ_LOCK;
      cnt_q    <= '0;
      boost_en <= 1'b0;
      src_en   <= 1'b0;
    end else if (ev_sleep) begin
      st_q     <= SQ_SLEEP;
      boost_en <= 1'b0;
      src_en   <= 1'b0;
    end else if (ev_shd) begin
      boost_en <= 1'b0;
      src_en   <= 1'b0;
    end else if (ev_pon) begin
      st_q     <= SQ_PWRUP;
      boost_en <= 1'b1;
      src_en   <= 1'b1;
    end else if (ev_poff) begin
      st_q   <= SQ_PWROFF;
      cnt_q  <= '0;
      src_en <= 1'b0;
    end else begin
      case (st_q)
        SQ_PWRUP: if (volt_ready) st_q <= SQ_IDLE;
        SQ_PWROFF: if (frame_tick) begin
          if (cnt_q == pof_last) begin
            boost_en <= 1'b0;
            st_q     <= SQ_IDLE;
          end else cnt_q <= cnt_q + CW'(1);
        end
        SQ_LOCK: if (us_tick) begin
          if (cnt_q == LOCK_LAST) st_q <= SQ_IDLE;
          else cnt_q <= cnt_q + CW'(1);
        end
        default: st_q <= st_q;
      endcase
    end
  end

  assign seq_busy   = (st_q != SQ_IDLE);
  assign deep_sleep = (st_q == SQ_SLEEP);
endmodule

// File: rtl/epd_cmd_seq.sv
module epd_cmd_seq #(
  parameter int RST_US = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_valid,
  input  logic       byte_is_data,
  input  logic [7:0] byte_val,
  input  logic       volt_ready,
  input  logic       wave_active,
  input  logic       frame_tick,
  input  logic       us_tick,
  output logic       busy_n,
  output logic       boost_en,
  output logic       src_en,
  output logic       deep_sleep,
  output logic [7:0] panel_cfg0,
  output logic [4:0] panel_cfg1,
  output logic [1:0] pof_code,
  output logic       drop_err,
  output logic       pix_we,
  output logic [7:0] pix_byte
);
  logic seq_busy, acc, dropped;
  logic ev_pon, ev_poff, ev_srst, ev_shd, ev_sleep;

  assign busy_n  = !(seq_busy || wave_active);
  assign acc     = byte_valid && busy_n;
  assign dropped = byte_valid && !busy_n;

  esq_decode u_dec (
    .clk(clk), .rst_n(rst_n), .acc(acc), .is_data(byte_is_data), .val(byte_val),
    .ev_pon(ev_pon), .ev_poff(ev_poff), .ev_srst(ev_srst), .ev_shd(ev_shd),
    .ev_sleep(ev_sleep), .cfg0(panel_cfg0), .cfg1(panel_cfg1),
    .pof_code(pof_code), .pix_we(pix_we), .pix_byte(pix_byte)
  );

  esq_power #(.RST_US(RST_US)) u_pwr (
    .clk(clk), .rst_n(rst_n), .ev_pon(ev_pon), .ev_poff(ev_poff),
    .ev_srst(ev_srst), .ev_shd(ev_shd), .ev_sleep(ev_sleep),
    .pof_code(pof_code), .volt_ready(volt_ready), .frame_tick(frame_tick),
    .us_tick(us_tick), .seq_busy(seq_busy), .boost_en(boost_en),
    .src_en(src_en), .deep_sleep(deep_sleep)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       drop_err <= 1'b0;
    else if (dropped) drop_err <= 1'b1;
  end
endmodule

// File: rtl/esq_chk.sv
module esq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_valid,
  input logic       byte_is_data,
  input logic [7:0] byte_val,
  input logic       wave_active,
  input logic       busy_n,
  input logic       boost_en,
  input logic       src_en,
  input logic       deep_sleep,
  input logic [7:0] panel_cfg0,
  input logic [4:0] panel_cfg1,
  input logic       drop_err,
  input logic       pix_we
);
  // R12
  drop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !busy_n) |=> drop_err);
  // R12
  drop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_err |=> drop_err);
  // R10
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deep_sleep |=> (deep_sleep && !boost_en));
  // R9
  sleep_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deep_sleep) |-> $past(byte_valid && byte_is_data && byte_val == 8'hA5));
  // R4
  boost_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(boost_en) || $rose(src_en)) |-> $past(byte_valid && !byte_is_data && byte_val == 8'h04));
  // R11
  wave_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wave_active |-> !busy_n);
  // R3
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(byte_valid && byte_is_data) |-> ($stable(panel_cfg0) && $stable(panel_cfg1) && !pix_we));
endmodule

bind epd_cmd_seq esq_chk i_esq_chk (
  .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_is_data(byte_is_data),
  .byte_val(byte_val), .wave_active(wave_active), .busy_n(busy_n),
  .boost_en(boost_en), .src_en(src_en), .deep_sleep(deep_sleep),
  .panel_cfg0(panel_cfg0), .panel_cfg1(panel_cfg1), .drop_err(drop_err),
  .pix_we(pix_we)
);

// File: tb/test_epd_cmd_seq.sv
module test_epd_cmd_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_valid = 1'b0, byte_is_data = 1'b0;
  logic [7:0] byte_val = 8'h00;
  logic volt_ready = 1'b0, wave_active = 1'b0, frame_tick = 1'b0, us_tick = 1'b0;
  logic busy_n, boost_en, src_en, deep_sleep, drop_err, pix_we;
  logic [7:0] panel_cfg0, pix_byte;
  logic [4:0] panel_cfg1;
  logic [1:0] pof_code;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  epd_cmd_seq i_epd_cmd_seq (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic dat, input logic [7:0] v);
    @(negedge clk);
    byte_valid = 1'b1; byte_is_data = dat; byte_val = v;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
  endtask

  task automatic pulse_us();
    @(negedge clk); us_tick = 1'b1;
    @(negedge clk); us_tick = 1'b0;
  endtask

  task automatic t_reset();
    hw_reset();
    chk("R1 busy_n", busy_n, 1); chk("R1 boost_en", boost_en, 0);
    chk("R1 deep_sleep", deep_sleep, 0); chk("R1 cfg0", panel_cfg0, 8'h0F);
    chk("R1 cfg1", panel_cfg1, 0); chk("R1 pof_code", pof_code, 0);
    chk("R1 drop_err", drop_err, 0); chk("R1 pix_we", pix_we, 0);
  endtask

  task automatic t_stray_and_panel();
    send(1, 8'h33);
    chk("R3 stray cfg0", panel_cfg0, 8'h0F); chk("R3 stray pix_we", pix_we, 0);
    send(0, 8'h00); send(1, 8'h8B); send(1, 8'h1A); send(1, 8'h03);
    chk("R2 cfg0", panel_cfg0, 8'h8B); chk("R2 cfg1", panel_cfg1, 5'h1A);
    send(0, 8'h55); send(1, 8'h21);
    chk("R3 after undefined cmd", panel_cfg0, 8'h8B); chk("R3 no pix_we", pix_we, 0);
  endtask

  task automatic t_power();
    volt_ready = 1'b0;
    send(0, 8'h04);
    chk("R4 boost on", boost_en, 1); chk("R4 src on", src_en, 1); chk("R4 busy", busy_n, 0);
    repeat (3) @(negedge clk);
    chk("R4 busy held", busy_n, 0);
    volt_ready = 1'b1;
    @(negedge clk);
    chk("R4 busy released", busy_n, 1);
    send(0, 8'h03); send(1, 8'h2C);
    chk("R6 pof_code", pof_code, 2);
    send(0, 8'h02);
    chk("R5 src off", src_en, 0); chk("R5 boost kept", boost_en, 1); chk("R5 busy", busy_n, 0);
    pulse_frame(); pulse_frame();
    chk("R5 boost after 2 frames", boost_en, 1);
    pulse_frame();
    chk("R5 boost after 3 frames", boost_en, 0); chk("R5 busy released", busy_n, 1);
    chk("R5 regs kept", panel_cfg0, 8'h8B);
  endtask

  task automatic t_shutdown_bit();
    send(0, 8'h04); @(negedge clk);
    chk("R7 precondition boost", boost_en, 1);
    send(0, 8'h00); send(1, 8'h4D);
    chk("R7 boost off", boost_en, 0); chk("R7 src off", src_en, 0);
    chk("R7 cfg0 kept", panel_cfg0, 8'h4D);
    send(1, 8'h15);
    chk("R7 cfg1 still written", panel_cfg1, 5'h15);
  endtask

  task automatic t_wave_drop();
    @(negedge clk); wave_active = 1'b1;
    @(negedge clk);
    chk("R11 busy while wave", busy_n, 0);
    send(0, 8'h03); send(1, 8'h30);
    chk("R12 byte dropped", pof_code, 2); chk("R12 drop_err", drop_err, 1);
    wave_active = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 sticky", drop_err, 1);
  endtask

  task automatic t_soft_reset();
    send(0, 8'h04); @(negedge clk);
    send(0, 8'h00); send(1, 8'hF2);
    chk("R8 cfg0 default", panel_cfg0, 8'h0F); chk("R8 cfg1 default", panel_cfg1, 0);
    chk("R8 pof default", pof_code, 0); chk("R8 boost off", boost_en, 0);
    chk("R8 busy", busy_n, 0);
    send(0, 8'h03); send(1, 8'h10);
    chk("R8 ignored in lockout", pof_code, 0);
    for (int i = 0; i < 49; i++) pulse_us();
    chk("R8 busy at 49 us", busy_n, 0);
    pulse_us();
    chk("R8 busy at 50 us", busy_n, 1);
  endtask

  task automatic t_sleep();
    hw_reset();
    send(0, 8'h04); @(negedge clk);
    send(0, 8'h07); send(1, 8'h5A);
    chk("R9 wrong key", deep_sleep, 0); chk("R9 wrong key boost", boost_en, 1);
    send(0, 8'h07); send(1, 8'hA5);
    chk("R9 asleep", deep_sleep, 1); chk("R9 boost off", boost_en, 0); chk("R9 busy", busy_n, 0);
    send(0, 8'h04);
    repeat (3) @(negedge clk);
    chk("R10 still asleep", deep_sleep, 1); chk("R10 boost stays off", boost_en, 0);
    hw_reset();
    chk("R10 woken by reset", deep_sleep, 0); chk("R10 busy after reset", busy_n, 1);
  endtask

  task automatic t_stream();
    send(0, 8'h10);
    @(negedge clk); byte_valid = 1'b1; byte_is_data = 1'b1; byte_val = 8'h3C;
    @(negedge clk); byte_valid = 1'b0;
    chk("R13 pix_we", pix_we, 1); chk("R13 pix_byte", pix_byte, 8'h3C);
    @(negedge clk);
    chk("R13 one cycle", pix_we, 0);
    send(1, 8'hC3);
    chk("R13 second byte", pix_byte, 8'hC3);
    send(0, 8'h55); send(1, 8'h77);
    chk("R13 ended by command", pix_we, 0);
  endtask

  initial begin
    t_reset();
    t_stray_and_panel();
    t_power();
    t_shutdown_bit();
    t_wave_drop();
    t_soft_reset();
    t_sleep();
    t_stream();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule